// File: doc/BRIEF.md
# Asynchronous Memory Bus Front End

This block sits on the device side of a parallel asynchronous memory bus and watches the host's control pins through a fast sampling clock. Three enable inputs, an output-enable, a write-enable and a reset/power-down input are synchronised and glitch-filtered. From the filtered pins the block decides each cycle which bus state applies: power-down, standby, write, read or output disabled. It drives the output enable of the data tri-state buffers only during a valid read.

A write ends on whichever comes first: write-enable going high, or one of the enables dropping out. The block then emits a single-cycle strobe that carries the address and data seen on the last sample before that edge. A write during which output-enable was also asserted is rejected and reported on a separate error strobe. During a read, an idle timer raises an automatic low-power flag once the bus has been quiet for a set number of sample clocks. The data outputs stay driven while the flag is set.

Top module: `async_bus_front`

## Requirements
- R1: While reset is held, `op_o` is 0 (power-down), and `dq_oe_o`, `wr_stb_o`, `proto_err_o` and `auto_lp_o` are all 0.
- R2: `op_o` encodes the bus state as 0 power-down, 1 standby, 2 write, 3 read, 4 output disabled. The priority is power-down, then standby, then write, then read, with output disabled as the remaining case.
- R3: `dq_oe_o` is 1 only in the read state: device enabled, output-enable low, write-enable high and not in power-down. Otherwise it is 0.
- R4: When the combined enable is inactive, the state is standby and `dq_oe_o` is 0, whatever output-enable and write-enable do.
- R5: When `rp_ni` is low, the state is power-down and `dq_oe_o` is 0, regardless of every other pin.
- R6: A level on any enable or on write-enable that lasts fewer than `GLITCH_CYC` sample clocks is ignored. It neither starts nor ends an operation. A level that lasts exactly `GLITCH_CYC` clocks is accepted.
- R7: When a write ends, `wr_stb_o` pulses for one cycle. `wr_addr_o`/`wr_data_o` then hold the address and data of the last sample before the first terminating edge. Later bus changes do not alter them.
- R8: The combined enable is the AND of `en_i[2:0]`. Bit i of `EN_ACT_HIGH` set means input i is active high. The default 3'b110 makes `en_i[0]` active low and the others active high. The device counts as disabled as soon as any one input deasserts.
- R9: If output-enable is low at any point during a write, `proto_err_o` pulses for one cycle when the write ends, and no `wr_stb_o` is issued.
- R10: In the read state, `auto_lp_o` rises after `IDLE_CYC` sample clocks with no change on the control pins or the address. It clears on the next change. `dq_oe_o` stays 1 while it is set.
- R11: `auto_lp_o` is 0 in every state other than read.
- R12: A write cut short by power-down produces neither strobe.
- R13: `op_o` and `dq_oe_o` change `SYNC_STAGES+GLITCH_CYC+1` clock edges after a stable pin change. The strobes follow the terminating edge after the same number of edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 3 | Enable inputs, polarity set per bit by `EN_ACT_HIGH` |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| rp_ni | input | 1 | Reset/power-down, low means power-down |
| addr_i | input | ADDR_W | Address bus |
| dq_i | input | DATA_W | Data bus input side |
| op_o | output | 3 | Current bus state code |
| dq_oe_o | output | 1 | Data tri-state buffer enable |
| wr_stb_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | ADDR_W | Captured write address |
| wr_data_o | output | DATA_W | Captured write data |
| proto_err_o | output | 1 | One-cycle rejected-write strobe |
| auto_lp_o | output | 1 | Automatic low-power flag |

## Verification
Each pin change that holds its level reaches `op_o` and `dq_oe_o` six edges later with the default parameters: two synchroniser stages, three filter samples and the state register. The write and error strobes appear six edges after the terminating edge. The bench drives on falling edges and checks the latency boundary directly. It samples once on the fifth falling edge, where the old value must still hold, and once on the sixth, where the new value must appear. Other state checks wait eight cycles. A monitor pops the scoreboard queue on every strobe, so ordering and timing of strobes are checked against what the driver tasks queued. The idle flag is checked with windows placed well either side of the `IDLE_CYC` count.

// File: rtl/abf_pkg.sv
package abf_pkg;
   typedef enum logic [2:0] {
      OP_PDOWN   = 3'd0,
      OP_STANDBY = 3'd1,
      OP_WRITE   = 3'd2,
      OP_READ    = 3'd3,
      OP_ODIS    = 3'd4
   } abf_op_e;
endpackage

// File: rtl/abf_pin_filter.sv
module abf_pin_filter #(
   parameter int   SYNC_STAGES = 2,
   parameter int   GLITCH_CYC  = 3,
   parameter logic RST_VAL     = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_i,
   output logic filt_o
);
   localparam int CW = (GLITCH_CYC > 1) ? $clog2(GLITCH_CYC) : 1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   smp;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= {SYNC_STAGES{RST_VAL}};
      else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
   end
   assign smp = sync_q[SYNC_STAGES-1];

   generate
      if (GLITCH_CYC == 1) begin : g_direct
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) filt_o <= RST_VAL;
            else         filt_o <= smp;
         end
      end else begin : g_count
         localparam logic [CW-1:0] LAST = CW'(GLITCH_CYC - 1);
         logic [CW-1:0] run_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               run_q  <= '0;
               filt_o <= RST_VAL;
            end else if (smp != filt_o) begin
               if (run_q == LAST) begin
                  filt_o <= smp;
                  run_q  <= '0;
               end else begin
                  run_q <= run_q + 1'b1;
               end
            end else begin
               run_q <= '0;
            end
         end
      end
   endgenerate

   assert_filter_follow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (filt_o != $past(filt_o)) |-> (filt_o == $past(smp)));
endmodule

// File: rtl/abf_bus_delay.sv
module abf_bus_delay #(
   parameter int W     = 24,
   parameter int DEPTH = 5
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] bus_i,
   output logic [W-1:0] bus_o
);
   logic [W-1:0] pipe_q [DEPTH];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < DEPTH; i++) pipe_q[i] <= '0;
      end else begin
         pipe_q[0] <= bus_i;
         for (int i = 1; i < DEPTH; i++) pipe_q[i] <= pipe_q[i-1];
      end
   end
   assign bus_o = pipe_q[DEPTH-1];
endmodule

// File: rtl/abf_write_track.sv
module abf_write_track #(
   parameter int AW = 8,
   parameter int DW = 16
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          wr_act_i,
   input  logic          oe_act_i,
   input  logic          pdown_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] data_i,
   output logic          wr_stb_o,
   output logic          err_stb_o,
   output logic [AW-1:0] addr_o,
   output logic [DW-1:0] data_o
);
   logic act_q, oe_seen_q, oe_seen_d, ending;

   assign oe_seen_d = wr_act_i ? ((act_q ? oe_seen_q : 1'b0) | oe_act_i) : oe_seen_q;
   assign ending    = act_q && !wr_act_i && !pdown_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_q     <= 1'b0;
         oe_seen_q <= 1'b0;
         wr_stb_o  <= 1'b0;
         err_stb_o <= 1'b0;
         addr_o    <= '0;
         data_o    <= '0;
      end else begin
         act_q     <= wr_act_i;
         oe_seen_q <= oe_seen_d;
         wr_stb_o  <= ending && !oe_seen_q;
         err_stb_o <= ending && oe_seen_q;
         if (wr_act_i) begin
            addr_o <= addr_i;
            data_o <= data_i;
         end
      end
   end

   assert_strobe_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_stb_o |=> !wr_stb_o);
   assert_capture_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_act_i && !act_q) |=> $stable(addr_o) && $stable(data_o));
   assert_stb_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_stb_o && err_stb_o));
endmodule

// File: rtl/abf_idle_timer.sv
module abf_idle_timer #(
   parameter int IDLE_CYC = 20
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic in_read_i,
   input  logic change_i,
   output logic alp_o
);
   localparam int            CW    = $clog2(IDLE_CYC + 1);
   localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYC);

   logic [CW-1:0] quiet_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     quiet_q <= '0;
      else if (!in_read_i || change_i) quiet_q <= '0;
      else if (quiet_q != LIMIT)       quiet_q <= quiet_q + 1'b1;
   end
   assign alp_o = (quiet_q == LIMIT);

   assert_alp_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (alp_o && in_read_i && !change_i) |=> alp_o);
endmodule

// File: rtl/async_bus_front.sv
module async_bus_front
   import abf_pkg::*;
#(
   parameter int         ADDR_W      = 8,
   parameter int         DATA_W      = 16,
   parameter int         SYNC_STAGES = 2,
   parameter int         GLITCH_CYC  = 3,
   parameter int         IDLE_CYC    = 20,
   parameter logic [2:0] EN_ACT_HIGH = 3'b110
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [2:0]        en_i,
   input  logic              oe_ni,
   input  logic              we_ni,
   input  logic              rp_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] dq_i,
   output logic [2:0]        op_o,
   output logic              dq_oe_o,
   output logic              wr_stb_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              proto_err_o,
   output logic              auto_lp_o
);
   localparam int         NPIN    = 6;
   localparam int         BUS_W   = ADDR_W + DATA_W;
   localparam int         ALIGN   = SYNC_STAGES + GLITCH_CYC;
   localparam logic [5:0] PIN_RST = {1'b0, 1'b1, 1'b1, ~EN_ACT_HIGH};

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (GLITCH_CYC < 1) begin : g_bad_glitch
         $error("GLITCH_CYC must be at least 1");
      end
      if (IDLE_CYC < 2) begin : g_bad_idle
         $error("IDLE_CYC must be at least 2");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("bus widths must be positive");
      end
   endgenerate

   logic [NPIN-1:0] pin_raw, pin_f, pin_f_q;
   assign pin_raw = {rp_ni, we_ni, oe_ni, en_i};

   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      abf_pin_filter #(
         .SYNC_STAGES (SYNC_STAGES),
         .GLITCH_CYC  (GLITCH_CYC),
         .RST_VAL     (PIN_RST[i])
      ) u_filt (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .pin_i  (pin_raw[i]),
         .filt_o (pin_f[i])
      );
   end

   logic [BUS_W-1:0]  bus_al;
   logic [ADDR_W-1:0] addr_al, addr_al_q;
   logic [DATA_W-1:0] data_al;

   abf_bus_delay #(.W(BUS_W), .DEPTH(ALIGN)) u_dly (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .bus_i  ({addr_i, dq_i}),
      .bus_o  (bus_al)
   );
   assign {addr_al, data_al} = bus_al;

   logic run_on, en_ok, oe_act, we_act, wr_act, change;
   assign run_on = pin_f[5];
   assign we_act = !pin_f[4];
   assign oe_act = !pin_f[3];
   assign en_ok  = &(pin_f[2:0] ~^ EN_ACT_HIGH);
   assign wr_act = run_on && en_ok && we_act;

   abf_op_e op_d, op_q;
   always_comb begin
      if (!run_on)     op_d = OP_PDOWN;
      else if (!en_ok) op_d = OP_STANDBY;
      else if (we_act) op_d = OP_WRITE;
      else if (oe_act) op_d = OP_READ;
      else             op_d = OP_ODIS;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         op_q      <= OP_PDOWN;
         dq_oe_o   <= 1'b0;
         pin_f_q   <= PIN_RST;
         addr_al_q <= '0;
      end else begin
         op_q      <= op_d;
         dq_oe_o   <= (op_d == OP_READ);
         pin_f_q   <= pin_f;
         addr_al_q <= addr_al;
      end
   end
   assign op_o   = op_q;
   assign change = (pin_f != pin_f_q) || (addr_al != addr_al_q);

   abf_write_track #(.AW(ADDR_W), .DW(DATA_W)) u_wr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_act_i  (wr_act),
      .oe_act_i  (oe_act),
      .pdown_i   (!run_on),
      .addr_i    (addr_al),
      .data_i    (data_al),
      .wr_stb_o  (wr_stb_o),
      .err_stb_o (proto_err_o),
      .addr_o    (wr_addr_o),
      .data_o    (wr_data_o)
   );

   abf_idle_timer #(.IDLE_CYC(IDLE_CYC)) u_idle (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .in_read_i (op_d == OP_READ),
      .change_i  (change),
      .alp_o     (auto_lp_o)
   );

   assert_pdown_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_on |=> (op_o == OP_PDOWN) && !dq_oe_o);
   assert_standby_hiz_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_on && !en_ok) |=> (op_o == OP_STANDBY) && !dq_oe_o);
   assert_read_drive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_on && en_ok && !we_act && oe_act) |=> dq_oe_o);
   assert_alp_only_read_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      auto_lp_o |-> (op_o == OP_READ) && dq_oe_o);
   assert_no_stb_pdown_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_on |=> !wr_stb_o && !proto_err_o);
endmodule

// File: tb/async_bus_front_bench.sv
module async_bus_front_bench;
   localparam int AW  = 8;
   localparam int DW  = 16;
   localparam int LAT = 6;
   localparam int IDL = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    en = 3'b001;
   logic          oe_n = 1'b1, we_n = 1'b1, rp_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] dq = '0;
   logic [2:0]    op;
   logic          dq_oe, wr_stb, perr, alp;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;

   int n_run = 0, n_fail = 0, n_stb = 0;
   logic [AW+DW:0] exp_q [$];

   always #4 clk = ~clk;

   async_bus_front u_async_bus_front (
      .clk_i (clk), .rst_ni (rst_n), .en_i (en), .oe_ni (oe_n), .we_ni (we_n),
      .rp_ni (rp_n), .addr_i (addr), .dq_i (dq), .op_o (op), .dq_oe_o (dq_oe),
      .wr_stb_o (wr_stb), .wr_addr_o (wr_addr), .wr_data_o (wr_data),
      .proto_err_o (perr), .auto_lp_o (alp)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (LAT + 2) @(negedge clk);
   endtask

   task automatic push(input logic is_err, input logic [AW-1:0] a, input logic [DW-1:0] d);
      exp_q.push_back({is_err, a, d});
   endtask

   always @(negedge clk) begin
      if (rst_n && (wr_stb || perr)) begin
         n_stb++;
         if (exp_q.size() == 0) begin
            check("R7/R9 unexpected strobe", {wr_stb, perr}, 2'b00);
         end else begin
            logic [AW+DW:0] e;
            e = exp_q.pop_front();
            if (e[AW+DW]) begin
               check("R9 error strobe", {wr_stb, perr}, 2'b01);
            end else begin
               check("R7 write strobe", {wr_stb, perr}, 2'b10);
               check("R7 write address", wr_addr, e[AW+DW-1:DW]);
               check("R7 write data", wr_data, e[DW-1:0]);
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      check("R1 op in reset", op, 0);
      check("R1 outputs in reset", {dq_oe, wr_stb, perr, alp}, 0);
      rst_n = 1'b1;
      settle();
      check("R4 standby after reset", op, 1);
      // R8 enable all three inputs: en[0] low, en[1], en[2] high
      en = 3'b110;
      settle();
      check("R2 output disabled", {op, dq_oe}, {3'd4, 1'b0});
      // R13 latency boundary on a read
      oe_n = 1'b0;
      repeat (LAT - 1) @(negedge clk);
      check("R13 not yet read", dq_oe, 0);
      @(negedge clk);
      check("R13 read on time", {op, dq_oe}, {3'd3, 1'b1});
      check("R3 read drives", dq_oe, 1);
      // R4 standby regardless of oe
      en[1] = 1'b0;
      settle();
      check("R4 R8 standby oe low", {op, dq_oe}, {3'd1, 1'b0});
      we_n = 1'b0;
      settle();
      check("R4 standby we low", {op, dq_oe}, {3'd1, 1'b0});
      we_n = 1'b1; en[1] = 1'b1;
      settle();
      // R5 power-down beats enabled read
      rp_n = 1'b0;
      settle();
      check("R5 power-down", {op, dq_oe}, {3'd0, 1'b0});
      rp_n = 1'b1; oe_n = 1'b1;
      settle();
      check("R2 back to output disabled", op, 4);

      // R7 write ended by write-enable
      addr = 8'h12; dq = 16'hBEEF; we_n = 1'b0;
      settle();
      check("R2 write state", {op, dq_oe}, {3'd2, 1'b0});
      push(1'b0, 8'h12, 16'hBEEF);
      we_n = 1'b1;
      settle();
      addr = 8'h99; dq = 16'h0;
      settle();
      check("R7 held after write", {wr_addr, wr_data}, {8'h12, 16'hBEEF});

      // R7 R8 write ended by one enable dropping first
      addr = 8'h34; dq = 16'h1234; we_n = 1'b0;
      settle();
      push(1'b0, 8'h34, 16'h1234);
      en[0] = 1'b1;
      repeat (2) @(negedge clk);
      addr = 8'hEE; dq = 16'hDEAD;
      settle();
      we_n = 1'b1;
      settle();
      en[0] = 1'b0;
      settle();

      // R7 last sample before the edge
      addr = 8'h40; dq = 16'h0001; we_n = 1'b0;
      settle();
      addr = 8'h41; dq = 16'h0002;
      settle();
      push(1'b0, 8'h41, 16'h0002);
      we_n = 1'b1;
      settle();

      // R6 short write-enable pulse ignored
      begin
         int base;
         base = n_stb;
         we_n = 1'b0;
         repeat (2) @(negedge clk);
         we_n = 1'b1;
         settle();
         check("R6 short we ignored", n_stb - base, 0);
         check("R6 state unchanged", op, 4);
      end
      // R6 pulse of exactly GLITCH_CYC accepted
      addr = 8'h55; dq = 16'h5A5A;
      push(1'b0, 8'h55, 16'h5A5A);
      we_n = 1'b0;
      repeat (3) @(negedge clk);
      we_n = 1'b1;
      settle();
      check("R6 boundary pulse accepted", exp_q.size(), 0);
      // R6 short enable dropout does not end a write
      begin
         int base;
         base = n_stb;
         addr = 8'h66; dq = 16'h6666; we_n = 1'b0;
         settle();
         en[2] = 1'b0;
         repeat (2) @(negedge clk);
         en[2] = 1'b1;
         settle();
         check("R6 enable glitch no end", n_stb - base, 0);
         push(1'b0, 8'h66, 16'h6666);
         we_n = 1'b1;
         settle();
      end

      // R9 write with output-enable low
      push(1'b1, 8'h0, 16'h0);
      oe_n = 1'b0; we_n = 1'b0;
      settle();
      we_n = 1'b1; oe_n = 1'b1;
      settle();
      check("R9 error consumed", exp_q.size(), 0);

      // R12 power-down during write
      begin
         int base;
         base = n_stb;
         addr = 8'h77; we_n = 1'b0;
         settle();
         rp_n = 1'b0;
         settle();
         we_n = 1'b1;
         settle();
         check("R12 no strobe", n_stb - base, 0);
         rp_n = 1'b1;
         settle();
      end

      // R10 automatic low power during quiet read
      oe_n = 1'b0;
      settle();
      repeat (IDL - 12) @(negedge clk);
      check("R10 not yet idle", alp, 0);
      repeat (IDL) @(negedge clk);
      check("R10 idle flag set", {alp, dq_oe}, 2'b11);
      addr = 8'h78;
      settle();
      check("R10 cleared on change", {alp, dq_oe}, 2'b01);
      // R11 no flag outside read
      oe_n = 1'b1;
      repeat (IDL * 2) @(negedge clk);
      check("R11 output disabled quiet", alp, 0);
      en = 3'b001;
      repeat (IDL * 2) @(negedge clk);
      check("R11 standby quiet", alp, 0);

      check("R7 scoreboard drained", exp_q.size(), 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule